// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Hart Partitioning

This block is a small, fully associative translation lookaside buffer. Every entry carries a 15-bit address-space tag next to its virtual page number. A lookup can only hit an entry whose tag equals the key built from the requester's current ASID. Translations from many processes can therefore stay resident together, and a process switch does not need a flush. A lookup is presented on one cycle and its hit flag and physical page number come back on the next.

Several harts can share one buffer. In that case the top log2(N_HARTS) bits of the tag record which hart installed the entry, and software sees a narrower ASID made of the remaining low bits. A mode bit, cleared at reset and written through a configuration strobe, declares that every hart sees the same address space for a given ASID. While that bit is set, the hart bits take no part in the compare and the whole 15-bit ASID supplied by software is used as the tag. Entries are installed through a fill port. The buffer can be cleared completely, or only for the entries that match one address-space key.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid and rsp_valid is 0. Any lookup made after reset misses.
- R2: A lookup presented with lk_valid high in cycle t is answered with rsp_valid high in cycle t+1, and only then. On a hit, rsp_ppn is the stored physical page number. On a miss, rsp_hit is 0 and rsp_ppn is 0.
- R3: A lookup hits only when the entry is valid, its virtual page number equals lk_vpn, and its tag equals the lookup key. A different ASID or a different page misses.
- R4: In the default mode (shared bit 0) with N_HARTS = 4, the key is built as follows. Bits 14:13 hold the hart ID and bits 12:0 hold ASID bits 12:0. ASID bits 14:13 are ignored, and an entry installed by one hart misses for another hart.
- R5: In shared mode (shared bit 1) the key is the full 15-bit ASID and the hart ID is ignored. The tag stored by an earlier default-mode fill is compared unchanged, so it can match a 15-bit ASID whose top bits equal the hart ID that installed it.
- R6: The shared bit is 0 after reset. A cycle with cfg_wr high loads it from cfg_shared, and the new mode applies from the next cycle.
- R7: A fill that matches no existing entry is written to the slot named by a round-robin pointer. The pointer then advances by one and wraps after slot 15. The 17th such fill therefore evicts the 1st.
- R8: A fill whose page and key match a valid entry overwrites that entry in place and leaves the pointer unchanged, so no other entry is evicted.
- R9: flush_all invalidates every entry in a single cycle.
- R10: A flush by ASID invalidates only the entries whose tag equals the key built from flush_asid and flush_hart under the current mode. All other entries stay valid.
- R11: When a fill and a flush fall in the same cycle, the flush acts first and the newly filled entry survives. A lookup made in the same cycle as a fill sees the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load the shared-mode bit |
| cfg_shared | input | 1 | New value for the shared-mode bit |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | 15 | Lookup ASID |
| lk_hart | input | HART_W | Requesting hart |
| rsp_valid | output | 1 | Lookup answer valid (one cycle after request) |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ppn | output | PPN_W | Physical page number, 0 on miss |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Virtual page number to install |
| fill_asid | input | 15 | ASID of the installing context |
| fill_hart | input | HART_W | Installing hart |
| fill_ppn | input | PPN_W | Physical page number to install |
| flush_all | input | 1 | Invalidate every entry |
| flush_asid_valid | input | 1 | Invalidate entries matching one key |
| flush_asid | input | 15 | ASID for the selective flush |
| flush_hart | input | HART_W | Hart for the selective flush key |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a fill and a flush: the bench raises flush_all together with a fill of a new page. It judges the result with lookups that expect the new page to hit and an older page to miss. The second pair is a fill and a lookup of the same page: the bench issues both in one cycle and expects a miss, then repeats the lookup alone and expects a hit. The same ordering is also checked by properties on the valid vector and on the replacement pointer.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  localparam int TAG_W      = 15;
  localparam int HART_MAX_W = 2;

  // Builds the compare key: in default mode the top hb bits carry the hart.
  function automatic logic [TAG_W-1:0] tag_key(
    input logic [TAG_W-1:0]      asid,
    input logic [HART_MAX_W-1:0] hart,
    input int unsigned           hb,
    input logic                  shared
  );
    logic [TAG_W-1:0] hmask;
    logic [TAG_W-1:0] hpart;
    hmask = ~({TAG_W{1'b1}} >> hb);
    hpart = {{(TAG_W-HART_MAX_W){1'b0}}, hart} << (TAG_W - int'(hb));
    if (shared) return asid;
    return (asid & ~hmask) | (hpart & hmask);
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int TAG_W   = 15
) (
  input  logic [ENTRIES-1:0] valid,
  input  logic [VPN_W-1:0]   ent_vpn [ENTRIES],
  input  logic [TAG_W-1:0]   ent_tag [ENTRIES],
  input  logic [VPN_W-1:0]   vpn,
  input  logic [TAG_W-1:0]   key,
  output logic [ENTRIES-1:0] hits
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hits[e] = valid[e] && (ent_vpn[e] == vpn) && (ent_tag[e] == key);
  end
endmodule

// File: rtl/tlb_rr.sv
module tlb_rr #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (advance) ptr <= (ptr == IDX_W'(ENTRIES-1)) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int N_HARTS = 4,
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  localparam int HB     = $clog2(N_HARTS),
  localparam int HART_W = (HB == 0) ? 1 : HB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_shared,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [TAG_W-1:0]  lk_asid,
  input  logic [HART_W-1:0] lk_hart,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PPN_W-1:0]  rsp_ppn,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [TAG_W-1:0]  fill_asid,
  input  logic [HART_W-1:0] fill_hart,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic              flush_all,
  input  logic              flush_asid_valid,
  input  logic [TAG_W-1:0]  flush_asid,
  input  logic [HART_W-1:0] flush_hart
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic               shared_q;

  // Named internal events (observed by the checker)
  logic [ENTRIES-1:0] lk_hits;
  logic [ENTRIES-1:0] fill_hits;
  logic [ENTRIES-1:0] kill_vec;
  logic               fill_hit;
  logic [IDX_W-1:0]   victim_ptr;
  logic [IDX_W-1:0]   fill_idx;
  logic [PPN_W-1:0]   lk_ppn;

  logic [TAG_W-1:0] lk_key, fill_key, flush_key;
  assign lk_key    = tag_key(lk_asid,    HART_MAX_W'(lk_hart),    HB, shared_q);
  assign fill_key  = tag_key(fill_asid,  HART_MAX_W'(fill_hart),  HB, shared_q);
  assign flush_key = tag_key(flush_asid, HART_MAX_W'(flush_hart), HB, shared_q);

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .TAG_W(TAG_W)) u_lk_match (
    .valid(valid_q), .ent_vpn(vpn_q), .ent_tag(tag_q),
    .vpn(lk_vpn), .key(lk_key), .hits(lk_hits)
  );

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .TAG_W(TAG_W)) u_fill_match (
    .valid(valid_q), .ent_vpn(vpn_q), .ent_tag(tag_q),
    .vpn(fill_vpn), .key(fill_key), .hits(fill_hits)
  );

  assign fill_hit = |fill_hits;

  tlb_rr #(.ENTRIES(ENTRIES)) u_rr (
    .clk(clk), .rst_n(rst_n),
    .advance(fill_valid && !fill_hit),
    .ptr(victim_ptr)
  );

  always_comb begin
    fill_idx = victim_ptr;
    lk_ppn   = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (fill_hits[e]) fill_idx = IDX_W'(e);
      if (lk_hits[e])   lk_ppn   = lk_ppn | ppn_q[e];
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_kill
    assign kill_vec[e] = flush_all || (flush_asid_valid && (tag_q[e] == flush_key));
  end

  // Valid bits and mode: flush first, fill on top
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= '0;
      shared_q <= 1'b0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (fill_valid && (fill_idx == IDX_W'(e))) valid_q[e] <= 1'b1;
        else if (kill_vec[e])                      valid_q[e] <= 1'b0;
      end
      if (cfg_wr) shared_q <= cfg_shared;
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (fill_valid && (fill_idx == IDX_W'(e))) begin
        vpn_q[e] <= fill_vpn;
        tag_q[e] <= fill_key;
        ppn_q[e] <= fill_ppn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ppn   <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && (|lk_hits);
      rsp_ppn   <= lk_valid ? lk_ppn : '0;
    end
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int ENTRIES = 16,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_wr,
  input logic               cfg_shared,
  input logic               shared_q,
  input logic               lk_valid,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic [PPN_W-1:0]   rsp_ppn,
  input logic               fill_valid,
  input logic               fill_hit,
  input logic               flush_all,
  input logic [ENTRIES-1:0] lk_hits,
  input logic [ENTRIES-1:0] valid_q,
  input logic [IDX_W-1:0]   victim_ptr
);
  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  assert_miss_ppn_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0));
  assert_single_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hits));
  assert_mode_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (shared_q == $past(cfg_shared)));
  assert_ptr_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_hit) |=>
      (victim_ptr == (($past(victim_ptr) == IDX_W'(ENTRIES-1)) ? '0 : $past(victim_ptr) + 1'b1)));
  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_hit) |=> $stable(victim_ptr));
  assert_flush_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !fill_valid) |=> (valid_q == '0));
  assert_fill_survives_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && fill_valid) |=> ($countones(valid_q) == 1));
endmodule

bind asid_tlb asid_tlb_chk #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_shared(cfg_shared),
  .shared_q(shared_q), .lk_valid(lk_valid), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .fill_valid(fill_valid),
  .fill_hit(fill_hit), .flush_all(flush_all), .lk_hits(lk_hits),
  .valid_q(valid_q), .victim_ptr(victim_ptr)
);

// File: tb/asid_tlb_test.sv
`timescale 1ns/1ps
module asid_tlb_test;
  localparam logic [1:0] OP_FILL = 2'd0, OP_LOOK = 2'd1, OP_FLSH = 2'd2, OP_CFG = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [19:0] vpn;
    logic [14:0] asid;
    logic [1:0]  hart;
    logic [19:0] ppn;   // fill: data; lookup: expected ppn; cfg: bit0 = mode
    logic        hit;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{OP_FILL, 20'h00010, 15'h0005, 2'd0, 20'hAAAAA, 1'b0},
    '{OP_LOOK, 20'h00010, 15'h0005, 2'd0, 20'hAAAAA, 1'b1}, // R2 hit
    '{OP_LOOK, 20'h00010, 15'h0006, 2'd0, 20'h00000, 1'b0}, // R3 other asid
    '{OP_LOOK, 20'h00011, 15'h0005, 2'd0, 20'h00000, 1'b0}, // R3 other page
    '{OP_LOOK, 20'h00010, 15'h0005, 2'd1, 20'h00000, 1'b0}, // R4 other hart
    '{OP_LOOK, 20'h00010, 15'h6005, 2'd0, 20'hAAAAA, 1'b1}, // R4 top asid bits ignored
    '{OP_FILL, 20'h00020, 15'h0003, 2'd2, 20'h12345, 1'b0},
    '{OP_CFG,  20'h00000, 15'h0000, 2'd0, 20'h00001, 1'b0}, // R6 set shared
    '{OP_LOOK, 20'h00020, 15'h4003, 2'd0, 20'h12345, 1'b1}, // R5 stored key 0x4003
    '{OP_LOOK, 20'h00010, 15'h6005, 2'd0, 20'h00000, 1'b0}, // R5 full compare
    '{OP_FILL, 20'h00030, 15'h7FFF, 2'd3, 20'h0F0F0, 1'b0},
    '{OP_LOOK, 20'h00030, 15'h7FFF, 2'd1, 20'h0F0F0, 1'b1}, // R5 hart ignored
    '{OP_FLSH, 20'h00000, 15'h4003, 2'd0, 20'h00000, 1'b0}, // R10
    '{OP_LOOK, 20'h00020, 15'h4003, 2'd0, 20'h00000, 1'b0}, // R10 removed
    '{OP_LOOK, 20'h00030, 15'h7FFF, 2'd0, 20'h0F0F0, 1'b1}, // R10 kept
    '{OP_CFG,  20'h00000, 15'h0000, 2'd0, 20'h00000, 1'b0}, // R6 back to default
    '{OP_LOOK, 20'h00010, 15'h0005, 2'd0, 20'hAAAAA, 1'b1}, // R6
    '{OP_FILL, 20'h00010, 15'h0005, 2'd0, 20'hBBBBB, 1'b0}, // R8 overwrite
    '{OP_LOOK, 20'h00010, 15'h0005, 2'd0, 20'hBBBBB, 1'b1}, // R8
    '{OP_FLSH, 20'h00000, 15'h0005, 2'd1, 20'h00000, 1'b0}, // R10 other hart key
    '{OP_LOOK, 20'h00010, 15'h0005, 2'd0, 20'hBBBBB, 1'b1}  // R10 survives
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_shared = 0;
  logic lk_valid = 0;
  logic [19:0] lk_vpn = '0;
  logic [14:0] lk_asid = '0;
  logic [1:0]  lk_hart = '0;
  logic rsp_valid, rsp_hit;
  logic [19:0] rsp_ppn;
  logic fill_valid = 0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic [14:0] fill_asid = '0;
  logic [1:0]  fill_hart = '0;
  logic flush_all = 0, flush_asid_valid = 0;
  logic [14:0] flush_asid = '0;
  logic [1:0]  flush_hart = '0;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  asid_tlb uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_shared(cfg_shared),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_hart(lk_hart),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_hart(fill_hart), .fill_ppn(fill_ppn), .flush_all(flush_all),
    .flush_asid_valid(flush_asid_valid), .flush_asid(flush_asid), .flush_hart(flush_hart)
  );

  task automatic check(input bit ok, input string req, input logic [21:0] act, input logic [21:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_fill(input logic [19:0] v, input logic [14:0] a, input logic [1:0] h, input logic [19:0] p);
    fill_valid = 1; fill_vpn = v; fill_asid = a; fill_hart = h; fill_ppn = p;
  endtask

  task automatic set_look(input logic [19:0] v, input logic [14:0] a, input logic [1:0] h);
    lk_valid = 1; lk_vpn = v; lk_asid = a; lk_hart = h;
  endtask

  task automatic idle_all();
    fill_valid = 0; lk_valid = 0; flush_all = 0; flush_asid_valid = 0; cfg_wr = 0;
  endtask

  task automatic do_fill(input logic [19:0] v, input logic [14:0] a, input logic [1:0] h, input logic [19:0] p);
    @(negedge clk); set_fill(v, a, h, p);
    @(negedge clk); idle_all();
  endtask

  // Response is checked one cycle after the request (R2)
  task automatic do_look(input logic [19:0] v, input logic [14:0] a, input logic [1:0] h,
                         input bit eh, input logic [19:0] ep, input string req);
    @(negedge clk); set_look(v, a, h);
    @(negedge clk); idle_all();
    check(rsp_valid && (rsp_hit == eh) && (rsp_ppn == (eh ? ep : 20'h0)), req,
          {rsp_valid, rsp_hit, rsp_ppn}, {1'b1, eh, eh ? ep : 20'h0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R1 rsp_valid in reset", {21'b0, rsp_valid}, 22'h0);
    rst_n = 1'b1;
    do_look(20'h00010, 15'h0005, 2'd0, 1'b0, 20'h0, "R1 empty after reset");

    // Table walk
    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_FILL: do_fill(VECS[i].vpn, VECS[i].asid, VECS[i].hart, VECS[i].ppn);
        OP_LOOK: do_look(VECS[i].vpn, VECS[i].asid, VECS[i].hart, VECS[i].hit, VECS[i].ppn,
                         $sformatf("vector %0d (R2..R10)", i));
        OP_FLSH: begin
          @(negedge clk); flush_asid_valid = 1; flush_asid = VECS[i].asid; flush_hart = VECS[i].hart;
          @(negedge clk); idle_all();
        end
        default: begin
          @(negedge clk); cfg_wr = 1; cfg_shared = VECS[i].ppn[0];
          @(negedge clk); idle_all();
        end
      endcase
    end

    // R9: flush_all clears everything
    @(negedge clk); flush_all = 1;
    @(negedge clk); idle_all();
    do_look(20'h00010, 15'h0005, 2'd0, 1'b0, 20'h0, "R9 page 0x10 gone");
    do_look(20'h00030, 15'h7FFF, 2'd3, 1'b0, 20'h0, "R9 page 0x30 gone");

    // R7: sixteen fills, then a seventeenth evicts the first
    for (int k = 0; k < 16; k++) do_fill(20'h00100 + 20'(k), 15'h0011, 2'd0, 20'h50000 + 20'(k));
    do_look(20'h0010F, 15'h0011, 2'd0, 1'b1, 20'h5000F, "R7 last of sixteen");
    do_look(20'h00100, 15'h0011, 2'd0, 1'b1, 20'h50000, "R7 first of sixteen");
    do_fill(20'h00200, 15'h0011, 2'd0, 20'h60000);
    do_look(20'h00100, 15'h0011, 2'd0, 1'b0, 20'h0, "R7 oldest evicted");
    do_look(20'h00101, 15'h0011, 2'd0, 1'b1, 20'h50001, "R7 second kept");
    do_look(20'h00200, 15'h0011, 2'd0, 1'b1, 20'h60000, "R7 new entry");

    // R11: flush_all and fill in one cycle
    @(negedge clk); flush_all = 1; set_fill(20'h00300, 15'h0022, 2'd1, 20'h77777);
    @(negedge clk); idle_all();
    do_look(20'h00300, 15'h0022, 2'd1, 1'b1, 20'h77777, "R11 fill survives flush");
    do_look(20'h00101, 15'h0011, 2'd0, 1'b0, 20'h0, "R11 flush still applied");

    // R11: lookup in the same cycle as the fill of that page
    @(negedge clk); set_fill(20'h00400, 15'h0022, 2'd1, 20'h44444); set_look(20'h00400, 15'h0022, 2'd1);
    @(negedge clk); idle_all();
    check(rsp_valid && !rsp_hit, "R11 same-cycle lookup sees old state",
          {rsp_valid, rsp_hit, rsp_ppn}, {2'b10, 20'h0});
    do_look(20'h00400, 15'h0022, 2'd1, 1'b1, 20'h44444, "R11 later lookup hits");

    // R1/R6: reset again clears entries and the shared mode
    @(negedge clk); cfg_wr = 1; cfg_shared = 1;
    @(negedge clk); idle_all(); rst_n = 0;
    @(negedge clk); rst_n = 1;
    do_fill(20'h00500, 15'h2001, 2'd1, 20'h33333);
    do_look(20'h00400, 15'h0022, 2'd1, 1'b0, 20'h0, "R1 entries cleared by reset");
    do_look(20'h00500, 15'h0001, 2'd1, 1'b1, 20'h33333, "R6 default mode after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule